// File: doc/BRIEF.md
# Turn-Based Path Routing Port Selector

This block makes the routing decision for path-routed frames inside a six-port switch node. Each frame header carries a path field. The field holds a hop count and up to seven relative turns. A turn is not a destination address. It is a port offset counted from the port the frame came in on. On every hop the node applies the lowest turn, removes it from the path and lowers the hop count. The next switch then finds its own turn in the same place.

Frames that cannot be delivered are not forwarded. These are frames whose turn points past the last physical port, frames aimed at a port whose link is down, and frames whose path ends at a switch rather than an end node. For each of these the block raises an event strobe with a two-bit reason code and the arrival port, so the event can be sent back toward the edge node that originated the frame. A frame whose path ends at an end node is flagged for local delivery. Every decision is registered and appears exactly one clock after the header is presented.

The decision is held in a small state register with four states:
- ST_IDLE: no header was presented in the previous cycle.
- ST_FORWARD: the frame goes out on `out_port` with the updated path.
- ST_DELIVER: the frame terminates at this end node.
- ST_EVENT: a path event is reported.

From any state, the next state follows from the current cycle's inputs:
- Without `hdr_valid`, the next state is ST_IDLE.
- With a zero hop count, the next state is ST_DELIVER or ST_EVENT, depending on `is_end_node`.
- With a nonzero hop count, the next state is ST_EVENT for a missing or down port, and ST_FORWARD otherwise.

Top module: `path_turn_router`

## Requirements
- R1: The path field is 24 bits. Bits [2:0] are the hop count, and turn k (k = 1..7) sits in bits [3k+2:3k]. The turn applied at this node is always turn 1, bits [5:3].
- R2: With `hdr_valid`, a nonzero hop count, a target port below 6 and that port's `link_up` bit set, `fwd_valid` is high in the next cycle. In that case `out_port` = (`in_port` + turn 1) mod 8.
- R3: On a forward, `path_out` holds the hop count minus one in bits [2:0], turns 2..7 shifted down one field into bits [20:3], and zero in bits [23:21].
- R4: A nonzero hop count whose target port is 6 or 7 gives `evt_valid` with `evt_code` 2'b10 in the next cycle, and no forward.
- R5: A nonzero hop count whose existing target port has its `link_up` bit low gives `evt_valid` with `evt_code` 2'b01 in the next cycle, and no forward.
- R6: A zero hop count while `is_end_node` is low gives `evt_valid` with `evt_code` 2'b11 in the next cycle. The turn fields are ignored in this case.
- R7: A zero hop count while `is_end_node` is high gives `local_valid` in the next cycle, with neither a forward nor an event.
- R8: With every event, `evt_port` equals the `in_port` of the header that caused it.
- R9: While `rst_n` is low, all strobes are low and `evt_code` is 2'b00.
- R10: A cycle without `hdr_valid` yields no strobe in the following cycle.
- R11: At most one of `fwd_valid`, `local_valid` and `evt_valid` is high in any cycle. `evt_code` is 2'b00 whenever `evt_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | A header is presented this cycle |
| hdr_path | input | 24 | Path field: hop count and seven turns |
| in_port | input | 3 | Arrival port index, 0..5 |
| link_up | input | 6 | Per-port link status, 1 = up |
| is_end_node | input | 1 | This node is an end node |
| fwd_valid | output | 1 | Forward decision strobe |
| out_port | output | 3 | Selected output port |
| path_out | output | 24 | Path field for the next hop |
| local_valid | output | 1 | Frame terminates at this node |
| evt_valid | output | 1 | Path event strobe |
| evt_code | output | 2 | Event reason: 01 down port, 10 nonexistent port, 11 path ends at a switch |
| evt_port | output | 3 | Port the event is sent back through |

## Verification
Every result (the three strobes, the selected port, the shortened path and the event code with its return port) is due exactly one clock edge after the header is applied. The bench drives inputs on the falling edge and computes the expected outcome at once from its own model. It compares that outcome on the next falling edge, so exactly one rising edge lies between stimulus and check. Idle cycles are compared the same way, which covers the rule that nothing appears without a header.

// File: rtl/prt_pkg.sv
package prt_pkg;

    // Decision held in the state register.
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_FORWARD = 2'd1,
        ST_DELIVER = 2'd2,
        ST_EVENT   = 2'd3
    } prt_state_e;

    // Path event reason codes.
    localparam logic [1:0] EVC_NONE      = 2'b00;
    localparam logic [1:0] EVC_LINK_DOWN = 2'b01;
    localparam logic [1:0] EVC_NO_PORT   = 2'b10;
    localparam logic [1:0] EVC_DEAD_END  = 2'b11;

endpackage

// File: rtl/prt_turn_target.sv
// Applies a relative turn to the arrival port and qualifies the result.
module prt_turn_target #(
    parameter int PORTS  = 6,
    parameter int PORT_W = 3
) (
    input  logic [PORT_W-1:0] in_port,
    input  logic [PORT_W-1:0] turn,
    input  logic [PORTS-1:0]  link_up,
    output logic [PORT_W-1:0] target,
    output logic              missing,
    output logic              down
);
    localparam int SLOTS = 2 ** PORT_W;

    logic [SLOTS-1:0] link_slots;

    always_comb begin
        // The sum wraps naturally at the field width.
        target     = in_port + turn;
        link_slots = SLOTS'(link_up);
        missing    = (int'(target) >= PORTS);
        down       = !missing && !link_slots[target];
    end
endmodule

// File: rtl/prt_path_advance.sv
// Consumes the lowest turn and decrements the hop count.
module prt_path_advance #(
    parameter int TURN_W = 3,
    parameter int TURNS  = 7
) (
    input  logic [(TURNS+1)*TURN_W-1:0] path_in,
    output logic [(TURNS+1)*TURN_W-1:0] path_next
);
    localparam int PATH_W = (TURNS + 1) * TURN_W;

    logic [TURN_W-1:0] fields [TURNS+1];

    generate
        for (genvar k = 0; k <= TURNS; k++) begin : g_field
            assign fields[k] = path_in[k*TURN_W +: TURN_W];
        end
    endgenerate

    always_comb begin
        path_next = '0;
        path_next[TURN_W-1:0] = fields[0] - TURN_W'(1);
        for (int k = 1; k < TURNS; k++) begin
            path_next[k*TURN_W +: TURN_W] = fields[k+1];
        end
        path_next[PATH_W-1 -: TURN_W] = '0;
    end
endmodule

// File: rtl/path_turn_router.sv
module path_turn_router #(
    parameter int PORTS  = 6,
    parameter int PORT_W = 3,
    parameter int TURNS  = 7,
    parameter int TURN_W = 3,
    localparam int PATH_W = (TURNS + 1) * TURN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hdr_valid,
    input  logic [PATH_W-1:0] hdr_path,
    input  logic [PORT_W-1:0] in_port,
    input  logic [PORTS-1:0]  link_up,
    input  logic              is_end_node,
    output logic              fwd_valid,
    output logic [PORT_W-1:0] out_port,
    output logic [PATH_W-1:0] path_out,
    output logic              local_valid,
    output logic              evt_valid,
    output logic [1:0]        evt_code,
    output logic [PORT_W-1:0] evt_port
);
    import prt_pkg::*;

    prt_state_e        state_q, state_d;
    logic [1:0]        code_q, code_d;
    logic [PORT_W-1:0] port_q, src_q;
    logic [PATH_W-1:0] path_q;

    logic [PORT_W-1:0] target;
    logic              missing, down;
    logic [PATH_W-1:0] path_next;
    logic              hops_left;

    prt_turn_target #(.PORTS(PORTS), .PORT_W(PORT_W)) u_target (
        .in_port (in_port),
        .turn    (PORT_W'(hdr_path[2*TURN_W-1 -: TURN_W])),
        .link_up (link_up),
        .target  (target),
        .missing (missing),
        .down    (down)
    );

    prt_path_advance #(.TURN_W(TURN_W), .TURNS(TURNS)) u_advance (
        .path_in   (hdr_path),
        .path_next (path_next)
    );

    assign hops_left = (hdr_path[TURN_W-1:0] != '0);

    // Next decision, derived from this cycle's header.
    always_comb begin
        state_d = ST_IDLE;
        code_d  = EVC_NONE;
        unique case ({hdr_valid, hops_left})
            2'b10: begin
                if (is_end_node) begin
                    state_d = ST_DELIVER;
                end else begin
                    state_d = ST_EVENT;
                    code_d  = EVC_DEAD_END;
                end
            end
            2'b11: begin
                if (missing) begin
                    state_d = ST_EVENT;
                    code_d  = EVC_NO_PORT;
                end else if (down) begin
                    state_d = ST_EVENT;
                    code_d  = EVC_LINK_DOWN;
                end else begin
                    state_d = ST_FORWARD;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and captured decision data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            code_q  <= EVC_NONE;
            port_q  <= '0;
            src_q   <= '0;
            path_q  <= '0;
        end else begin
            state_q <= state_d;
            code_q  <= code_d;
            if (hdr_valid) begin
                port_q <= target;
                src_q  <= in_port;
                path_q <= path_next;
            end
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        fwd_valid   = 1'b0;
        local_valid = 1'b0;
        evt_valid   = 1'b0;
        evt_code    = EVC_NONE;
        unique case (state_q)
            ST_FORWARD: fwd_valid = 1'b1;
            ST_DELIVER: local_valid = 1'b1;
            ST_EVENT: begin
                evt_valid = 1'b1;
                evt_code  = code_q;
            end
            default: ;
        endcase
        out_port = port_q;
        path_out = path_q;
        evt_port = src_q;
    end
endmodule

// File: rtl/prt_checker.sv
module prt_checker #(
    parameter int PORTS  = 6,
    parameter int PORT_W = 3,
    parameter int PATH_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hdr_valid,
    input logic [PATH_W-1:0] hdr_path,
    input logic              is_end_node,
    input logic              fwd_valid,
    input logic [PORT_W-1:0] out_port,
    input logic [PATH_W-1:0] path_out,
    input logic              local_valid,
    input logic              evt_valid,
    input logic [1:0]        evt_code
);
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fwd_valid, local_valid, evt_valid})); // R11

    AST_CODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_valid |-> evt_code == 2'b00); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_valid |=> !(fwd_valid || local_valid || evt_valid)); // R10

    AST_FWD_REAL_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> int'(out_port) < PORTS); // R4

    AST_TOP_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> path_out[PATH_W-1 -: 3] == 3'b000); // R3

    AST_DEAD_END: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid && hdr_path[2:0] == 3'b000 && !is_end_node
        |=> evt_valid && evt_code == 2'b11); // R6

    AST_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid && hdr_path[2:0] == 3'b000 && is_end_node
        |=> local_valid); // R7
endmodule

bind path_turn_router prt_checker #(
    .PORTS(PORTS), .PORT_W(PORT_W), .PATH_W(PATH_W)
) u_prt_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hdr_valid   (hdr_valid),
    .hdr_path    (hdr_path),
    .is_end_node (is_end_node),
    .fwd_valid   (fwd_valid),
    .out_port    (out_port),
    .path_out    (path_out),
    .local_valid (local_valid),
    .evt_valid   (evt_valid),
    .evt_code    (evt_code)
);

// File: tb/sim_path_turn_router.sv
`timescale 1ns/1ps
module sim_path_turn_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hdr_valid = 1'b0;
    logic [23:0] hdr_path = '0;
    logic [2:0]  in_port = '0;
    logic [5:0]  link_up = '0;
    logic        is_end_node = 1'b0;
    logic        fwd_valid, local_valid, evt_valid;
    logic [2:0]  out_port, evt_port;
    logic [23:0] path_out;
    logic [1:0]  evt_code;

    int vectors = 0;
    int errors  = 0;

    // Expected results for the next falling edge.
    logic        x_fwd = 1'b0, x_loc = 1'b0, x_evt = 1'b0;
    int          x_port = 0, x_src = 0;
    logic [23:0] x_path = '0;
    logic [1:0]  x_code = 2'b00;
    string       x_tag = "R10";

    always #10 clk = ~clk;

    path_turn_router u0 (
        .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_path(hdr_path),
        .in_port(in_port), .link_up(link_up), .is_end_node(is_end_node),
        .fwd_valid(fwd_valid), .out_port(out_port), .path_out(path_out),
        .local_valid(local_valid), .evt_valid(evt_valid), .evt_code(evt_code),
        .evt_port(evt_port)
    );

    initial begin
        #4000000;
        errors++;
        $display("FAIL watchdog: run did not complete (actual hung, expected done)");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    // Reference model of R1..R8 and R10.
    task automatic predict();
        int cnt, trn, tgt;
        cnt = int'(hdr_path[2:0]);
        trn = int'(hdr_path[5:3]);
        tgt = (int'(in_port) + trn) % 8;
        x_fwd = 1'b0; x_loc = 1'b0; x_evt = 1'b0; x_code = 2'b00;
        x_src = int'(in_port);
        if (!hdr_valid) begin
            x_tag = "R10";
        end else if (cnt == 0) begin
            if (is_end_node) begin x_loc = 1'b1; x_tag = "R7"; end
            else begin x_evt = 1'b1; x_code = 2'b11; x_tag = "R6"; end
        end else if (tgt >= 6) begin
            x_evt = 1'b1; x_code = 2'b10; x_tag = "R4";
        end else if (!link_up[tgt]) begin
            x_evt = 1'b1; x_code = 2'b01; x_tag = "R5";
        end else begin
            x_fwd  = 1'b1;
            x_port = tgt;
            x_path = {3'b000, hdr_path[23:6], 3'(cnt - 1)};
            x_tag  = "R2/R3";
        end
    endtask

    task automatic compare();
        vectors++;
        if ({fwd_valid, local_valid, evt_valid} != {x_fwd, x_loc, x_evt}) begin
            errors++;
            $display("FAIL %s strobes fwd/loc/evt actual %b%b%b expected %b%b%b",
                     x_tag, fwd_valid, local_valid, evt_valid, x_fwd, x_loc, x_evt);
        end else if (x_fwd && (int'(out_port) != x_port || path_out != x_path)) begin
            errors++;
            $display("FAIL %s port/path actual %0d/%h expected %0d/%h",
                     x_tag, out_port, path_out, x_port, x_path);
        end else if (evt_code != x_code) begin
            errors++;
            $display("FAIL %s R11 evt_code actual %b expected %b", x_tag, evt_code, x_code);
        end else if (x_evt && int'(evt_port) != x_src) begin
            errors++;
            $display("FAIL R8 evt_port actual %0d expected %0d", evt_port, x_src);
        end
    endtask

    task automatic apply(input logic v, input logic [23:0] p, input int ip,
                         input logic [5:0] lu, input logic en);
        @(negedge clk);
        compare();
        hdr_valid = v; hdr_path = p; in_port = 3'(ip);
        link_up = lu; is_end_node = en;
        predict();
    endtask

    function automatic logic [23:0] mk(input int cnt, input int t1, input int t2);
        return {15'h5AB1, 3'(t2), 3'(t1), 3'(cnt)};
    endfunction

    initial begin
        // R9: reset state, checked while reset is held.
        hdr_valid = 1'b1; hdr_path = mk(1, 1, 0); link_up = 6'h3F;
        repeat (3) @(negedge clk);
        x_tag = "R9";
        compare();
        @(negedge clk);
        hdr_valid = 1'b0;
        predict();
        rst_n = 1'b1;

        apply(1, mk(3, 2, 5), 1, 6'h3F, 0);   // R2/R3 forward to port 3
        apply(1, mk(1, 3, 0), 5, 6'h3F, 0);   // R2 wrap: (5+3)%8 = 0
        apply(1, mk(2, 1, 4), 5, 6'h3F, 1);   // R4 target 6
        apply(1, mk(2, 3, 4), 4, 6'h3F, 0);   // R4 target 7
        apply(1, mk(2, 2, 1), 0, 6'h3B, 0);   // R5 port 2 down
        apply(1, mk(0, 7, 7), 2, 6'h00, 0);   // R6 dead end, turns ignored
        apply(1, mk(0, 3, 1), 4, 6'h00, 1);   // R7 local delivery
        apply(0, mk(1, 1, 1), 0, 6'h3F, 0);   // R10 no header
        apply(1, 24'hFFFFFF, 0, 6'h3F, 0);    // R3 full path, target 7
        apply(1, 24'hDB6D2F, 2, 6'h3F, 0);    // R1/R3 count 7, turn 5 -> 7
        apply(1, 24'hFAC71F, 1, 6'h3F, 0);    // R1/R3 count 7, turn 3 -> 4
        apply(1, mk(7, 0, 6), 3, 6'h3F, 0);   // R2 turn 0 selects in_port

        for (int i = 0; i < 600; i++) begin
            apply(($urandom % 5) != 0, 24'($urandom), int'($urandom % 6),
                  6'($urandom), 1'($urandom));
        end
        apply(0, '0, 0, 6'h3F, 0);
        @(negedge clk);
        compare();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule